// File: doc/BRIEF.md
# Scanline timing and status generator

This block paces a fixed-size LCD frame. A two-state machine splits every line into a drawing phase and a horizontal-blank phase, each a fixed number of clock cycles. A line counter advances at the end of every horizontal-blank phase and wraps at the frame size. The block keeps horizontal-blank, vertical-blank and line-match flags. It raises interrupt and DMA request pulses when blanking starts and when the programmed line is reached.

The state machine has two states: `PH_DRAW`, the visible or vblank-line portion, and `PH_HBLANK`. It takes the transition `PH_DRAW -> PH_HBLANK` when the drawing cycle count expires. It takes `PH_HBLANK -> PH_DRAW` when the blanking cycle count expires, and that transition also steps the line counter. A single write port loads the target line and three interrupt enables. A read port returns those settings together with the live flags. A rendering stage downstream uses the line-start pulse to begin each line.

Top module: `scanline_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `line_num` is 0, the block is in cycle 0 of `PH_DRAW`, `line_start` is 1, and all flags, pulses, enables and the target line are 0.
- R2: Each line spends `DRAW_CYC` cycles in `PH_DRAW` and then `HBLANK_CYC` cycles in `PH_HBLANK`. `hblank_flag` is 1 exactly during `PH_HBLANK`, and `line_start` is 1 exactly in cycle 0 of `PH_DRAW`.
- R3: In the first cycle of every `PH_HBLANK`, on drawing and vblank lines alike, `hblank_dma` pulses. `hblank_irq` pulses in the same cycle when the hblank enable (register bit 3) is 1.
- R4: `line_num` increments in the first cycle of each new line and wraps from `LINES-1` to 0.
- R5: On every line change, `match_flag` becomes 1 if the new line equals the target line (register bits 6 and up) and 0 otherwise. When it becomes 1 and the match enable (bit 5) is 1, `match_irq` pulses in that cycle.
- R6: When the line counter becomes `VIS_LINES`, `vblank_flag` is set and `vblank_dma` pulses. `vblank_irq` pulses as well when the vblank enable (bit 4) is 1.
- R7: When the line counter becomes `LINES-1`, `vblank_flag` is cleared, one line before the wrap to 0.
- R8: A write with `cfg_we` high loads the enables (bits 3, 4 and 5) and the target line (bits 6 and up) at the next edge, and writes to bits 0 to 2 are ignored. `cfg_rdata` returns hblank flag at bit 0, vblank flag at bit 1 and match flag at bit 2, followed by the enables and the target in the same positions as the write.
- R9: Every interrupt and DMA output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the settings register |
| cfg_wdata | input | LINE_W+6 | Write data: enables at bits 3..5, target at 6 and up |
| cfg_rdata | output | LINE_W+6 | Flags at bits 0..2, enables at 3..5, target at 6 and up |
| line_num | output | LINE_W | Current line |
| line_start | output | 1 | High in cycle 0 of each line |
| hblank_flag | output | 1 | Horizontal-blank status |
| vblank_flag | output | 1 | Vertical-blank status |
| match_flag | output | 1 | Line-match status |
| hblank_irq | output | 1 | Horizontal-blank interrupt request pulse |
| vblank_irq | output | 1 | Vertical-blank interrupt request pulse |
| match_irq | output | 1 | Line-match interrupt request pulse |
| hblank_dma | output | 1 | Horizontal-blank DMA trigger pulse |
| vblank_dma | output | 1 | Vertical-blank DMA trigger pulse |

## Verification
Every result is due one clock edge after its cause. The line number, the match and vblank flags and their pulses appear in the first cycle of a new line. The hblank flag and its pulses appear in the first cycle of `PH_HBLANK`, and a settings write shows on `cfg_rdata` one edge after the strobe. The bench keeps its own cycle-position model. At each rising edge it pushes the expected outputs for the cycle that follows, and it compares them at the next falling edge. The model applies a settings write only after it has worked out the events of that edge, so it matches the one-edge latency of the enables.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
    typedef enum logic [0:0] {
        PH_DRAW   = 1'b0,
        PH_HBLANK = 1'b1
    } phase_t;

    // Settings/status register bit positions
    localparam int FLD_HBL = 0;
    localparam int FLD_VBL = 1;
    localparam int FLD_MT  = 2;
    localparam int FLD_HEN = 3;
    localparam int FLD_VEN = 4;
    localparam int FLD_MEN = 5;
    localparam int FLD_TGT = 6;
    localparam int N_EN    = 3;
endpackage

// File: rtl/scanline_phase_fsm.sv
module scanline_phase_fsm
    import scanline_pkg::*;
#(
    parameter int DRAW_CYC   = 960,
    parameter int HBLANK_CYC = 272
) (
    input  logic clk,
    input  logic rst,
    input  logic hblank_en,
    output logic hblank_flag,
    output logic line_start,
    output logic hblank_end,
    output logic hblank_irq,
    output logic hblank_dma
);
    localparam int MAX_CYC = (DRAW_CYC > HBLANK_CYC) ? DRAW_CYC : HBLANK_CYC;
    localparam int CYC_W   = $clog2(MAX_CYC + 1);
    localparam logic [CYC_W-1:0] DRAW_LAST = CYC_W'(DRAW_CYC - 1);
    localparam logic [CYC_W-1:0] HBL_LAST  = CYC_W'(HBLANK_CYC - 1);

    phase_t           state, state_nx;
    logic [CYC_W-1:0] cyc;
    logic             draw_end;
    logic             phase_done;

    // State register and cycle counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_DRAW;
            cyc   <= '0;
        end else begin
            state <= state_nx;
            cyc   <= phase_done ? '0 : cyc + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_DRAW:   if (draw_end)   state_nx = PH_HBLANK;
            PH_HBLANK: if (hblank_end) state_nx = PH_DRAW;
            default:   state_nx = PH_DRAW;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        draw_end    = (state == PH_DRAW)   && (cyc == DRAW_LAST);
        hblank_end  = (state == PH_HBLANK) && (cyc == HBL_LAST);
        phase_done  = draw_end || hblank_end;
        hblank_flag = (state == PH_HBLANK);
        line_start  = (state == PH_DRAW) && (cyc == '0);
    end

    // Pulses land in the first blanking cycle, aligned with the flag
    always_ff @(posedge clk) begin
        if (rst) begin
            hblank_irq <= 1'b0;
            hblank_dma <= 1'b0;
        end else begin
            hblank_irq <= draw_end && hblank_en;
            hblank_dma <= draw_end;
        end
    end
endmodule

// File: rtl/scanline_line_ctr.sv
module scanline_line_ctr #(
    parameter int LINES     = 228,
    parameter int VIS_LINES = 160,
    parameter int LINE_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [LINE_W-1:0] target,
    input  logic              vblank_en,
    input  logic              match_en,
    output logic [LINE_W-1:0] line_num,
    output logic              vblank_flag,
    output logic              match_flag,
    output logic              vblank_irq,
    output logic              vblank_dma,
    output logic              match_irq
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] VBL_FIRST = LINE_W'(VIS_LINES);

    logic [LINE_W-1:0] line_nx;
    logic              hit;

    always_comb begin
        line_nx = (line_num == LINE_LAST) ? '0 : line_num + 1'b1;
        hit     = (line_nx == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_num    <= '0;
            vblank_flag <= 1'b0;
            match_flag  <= 1'b0;
            vblank_irq  <= 1'b0;
            vblank_dma  <= 1'b0;
            match_irq   <= 1'b0;
        end else begin
            vblank_irq <= 1'b0;
            vblank_dma <= 1'b0;
            match_irq  <= 1'b0;
            if (step) begin
                line_num   <= line_nx;
                match_flag <= hit;
                match_irq  <= hit && match_en;
                if (line_nx == VBL_FIRST) begin
                    vblank_flag <= 1'b1;
                    vblank_irq  <= vblank_en;
                    vblank_dma  <= 1'b1;
                end else if (line_nx == LINE_LAST) begin
                    vblank_flag <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/scanline_cfg_reg.sv
module scanline_cfg_reg
    import scanline_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [LINE_W+N_EN-1:0]  wdata,
    output logic [LINE_W-1:0]       target,
    output logic [N_EN-1:0]         en
);
    // wdata[N_EN-1:0] carry the enables, the rest the target line
    for (genvar i = 0; i < N_EN; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)     en[i] <= 1'b0;
            else if (we) en[i] <= wdata[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     target <= '0;
        else if (we) target <= wdata[LINE_W+N_EN-1:N_EN];
    end
endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
    import scanline_pkg::*;
#(
    parameter  int DRAW_CYC   = 960,
    parameter  int HBLANK_CYC = 272,
    parameter  int LINES      = 228,
    parameter  int VIS_LINES  = 160,
    localparam int LINE_W     = $clog2(LINES),
    localparam int REG_W      = LINE_W + FLD_TGT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [LINE_W-1:0] line_num,
    output logic              line_start,
    output logic              hblank_flag,
    output logic              vblank_flag,
    output logic              match_flag,
    output logic              hblank_irq,
    output logic              vblank_irq,
    output logic              match_irq,
    output logic              hblank_dma,
    output logic              vblank_dma
);
    logic [LINE_W-1:0] target;
    logic [N_EN-1:0]   en;
    logic              hblank_end;
    logic              unused_ro_bits;

    assign unused_ro_bits = ^cfg_wdata[FLD_HEN-1:0];

    scanline_cfg_reg #(.LINE_W(LINE_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata[REG_W-1:FLD_HEN]),
        .target (target),
        .en     (en)
    );

    scanline_phase_fsm #(.DRAW_CYC(DRAW_CYC), .HBLANK_CYC(HBLANK_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hblank_en   (en[FLD_HEN-FLD_HEN]),
        .hblank_flag (hblank_flag),
        .line_start  (line_start),
        .hblank_end  (hblank_end),
        .hblank_irq  (hblank_irq),
        .hblank_dma  (hblank_dma)
    );

    scanline_line_ctr #(.LINES(LINES), .VIS_LINES(VIS_LINES), .LINE_W(LINE_W)) u_line (
        .clk         (clk),
        .rst         (rst),
        .step        (hblank_end),
        .target      (target),
        .vblank_en   (en[FLD_VEN-FLD_HEN]),
        .match_en    (en[FLD_MEN-FLD_HEN]),
        .line_num    (line_num),
        .vblank_flag (vblank_flag),
        .match_flag  (match_flag),
        .vblank_irq  (vblank_irq),
        .vblank_dma  (vblank_dma),
        .match_irq   (match_irq)
    );

    always_comb begin
        cfg_rdata          = '0;
        cfg_rdata[FLD_HBL] = hblank_flag;
        cfg_rdata[FLD_VBL] = vblank_flag;
        cfg_rdata[FLD_MT]  = match_flag;
        cfg_rdata[FLD_MEN:FLD_HEN] = en;
        cfg_rdata[REG_W-1:FLD_TGT] = target;
    end
endmodule

// File: rtl/scanline_timer_chk.sv
module scanline_timer_chk #(
    parameter int LINES     = 228,
    parameter int VIS_LINES = 160,
    parameter int LINE_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [LINE_W-1:0] line_num,
    input logic              hblank_flag,
    input logic              vblank_flag,
    input logic              match_flag,
    input logic              hblank_irq,
    input logic              vblank_irq,
    input logic              match_irq,
    input logic              hblank_dma,
    input logic              vblank_dma
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] VBL_FIRST = LINE_W'(VIS_LINES);

    a_r3_dma_on_hblank_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(hblank_flag) |-> hblank_dma);
    a_r3_irq_inside_hblank: assert property (@(posedge clk) disable iff (rst)
        hblank_irq |-> (hblank_flag && hblank_dma));
    a_r4_line_moves_at_hblank_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_num) |-> $fell(hblank_flag));
    a_r4_line_in_range: assert property (@(posedge clk) disable iff (rst)
        line_num <= LINE_LAST);
    a_r5_match_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        match_irq |-> match_flag);
    a_r6_vblank_entry: assert property (@(posedge clk) disable iff (rst)
        vblank_dma |-> (vblank_flag && line_num == VBL_FIRST));
    a_r6_vblank_irq_with_dma: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |-> vblank_dma);
    a_r7_vblank_clear_last_line: assert property (@(posedge clk) disable iff (rst)
        (line_num == LINE_LAST) |-> !vblank_flag);
    a_r6_vblank_only_blank_lines: assert property (@(posedge clk) disable iff (rst)
        vblank_flag |-> (line_num >= VBL_FIRST));
    a_r9_hdma_single: assert property (@(posedge clk) disable iff (rst)
        hblank_dma |=> !hblank_dma);
    a_r9_vdma_single: assert property (@(posedge clk) disable iff (rst)
        vblank_dma |=> !vblank_dma);
    a_r9_mirq_single: assert property (@(posedge clk) disable iff (rst)
        match_irq |=> !match_irq);
endmodule

bind scanline_timer scanline_timer_chk #(
    .LINES(LINES), .VIS_LINES(VIS_LINES), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst(rst), .line_num(line_num),
    .hblank_flag(hblank_flag), .vblank_flag(vblank_flag), .match_flag(match_flag),
    .hblank_irq(hblank_irq), .vblank_irq(vblank_irq), .match_irq(match_irq),
    .hblank_dma(hblank_dma), .vblank_dma(vblank_dma)
);

// File: tb/scanline_timer_test.sv
module scanline_timer_test;
    localparam int D   = 8;
    localparam int H   = 4;
    localparam int NL  = 12;
    localparam int VIS = 8;
    localparam int LC  = D + H;
    localparam int LW  = 4;
    localparam int RW  = LW + 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [RW-1:0] cfg_wdata;
    logic [RW-1:0] cfg_rdata;
    logic [LW-1:0] line_num;
    logic line_start, hblank_flag, vblank_flag, match_flag;
    logic hblank_irq, vblank_irq, match_irq, hblank_dma, vblank_dma;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    scanline_timer #(.DRAW_CYC(D), .HBLANK_CYC(H), .LINES(NL), .VIS_LINES(VIS)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .line_num(line_num), .line_start(line_start),
        .hblank_flag(hblank_flag), .vblank_flag(vblank_flag), .match_flag(match_flag),
        .hblank_irq(hblank_irq), .vblank_irq(vblank_irq), .match_irq(match_irq),
        .hblank_dma(hblank_dma), .vblank_dma(vblank_dma)
    );

    typedef struct packed {
        logic          inrst;
        logic [LW-1:0] line;
        logic ls, hb, vb, mt, hi, vi, mi, hd, vd;
        logic [RW-1:0] rd;
    } exp_t;

    exp_t q[$];

    // Reference model state
    int            pos;
    int            mline;
    bit            mvb, mmt, hen, ven, men;
    logic [LW-1:0] mtgt;

    // Driver side: predicts the outputs after each rising edge
    always @(posedge clk) begin
        exp_t e;
        e = '0;
        if (rst) begin
            pos = 0; mline = 0; mvb = 0; mmt = 0;
            hen = 0; ven = 0; men = 0; mtgt = '0;
            e.inrst = 1'b1;
            e.ls    = 1'b1;
        end else begin
            pos = pos + 1;
            if (pos == LC) pos = 0;
            e.hb = (pos >= D);
            e.hd = (pos == D);
            e.hi = (pos == D) && hen;
            e.ls = (pos == 0);
            if (pos == 0) begin
                mline = (mline + 1) % NL;
                mmt   = (mline == int'(mtgt));
                e.mi  = mmt && men;
                if (mline == VIS) begin
                    mvb = 1; e.vi = ven; e.vd = 1'b1;
                end else if (mline == NL - 1) begin
                    mvb = 0;
                end
            end
            if (cfg_we) begin
                hen  = cfg_wdata[3];
                ven  = cfg_wdata[4];
                men  = cfg_wdata[5];
                mtgt = cfg_wdata[RW-1:6];
            end
        end
        e.line = LW'(mline);
        e.vb   = mvb;
        e.mt   = mmt;
        e.rd   = {mtgt, men, ven, hen, mmt, mvb, e.hb};
        q.push_back(e);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    logic prev_pulse_hd, prev_pulse_mi;

    // Monitor side: compares away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (e.inrst) begin
                chk("R1", "reset line", int'(line_num), 0);
                chk("R1", "reset line_start", int'(line_start), 1);
                chk("R1", "reset rdata", int'(cfg_rdata), 0);
                chk("R1", "reset pulses",
                    int'({hblank_irq, vblank_irq, match_irq, hblank_dma, vblank_dma}), 0);
            end else begin
                chk("R4", "line_num", int'(line_num), int'(e.line));
                chk("R2", "line_start", int'(line_start), int'(e.ls));
                chk("R2", "hblank_flag", int'(hblank_flag), int'(e.hb));
                chk("R3", "hblank_dma", int'(hblank_dma), int'(e.hd));
                chk("R3", "hblank_irq", int'(hblank_irq), int'(e.hi));
                chk("R5", "match_flag", int'(match_flag), int'(e.mt));
                chk("R5", "match_irq", int'(match_irq), int'(e.mi));
                chk("R6 R7", "vblank_flag", int'(vblank_flag), int'(e.vb));
                chk("R6", "vblank_dma", int'(vblank_dma), int'(e.vd));
                chk("R6", "vblank_irq", int'(vblank_irq), int'(e.vi));
                chk("R8", "cfg_rdata", int'(cfg_rdata), int'(e.rd));
                chk("R9", "hblank_dma repeat", int'(prev_pulse_hd && hblank_dma), 0);
                chk("R9", "match_irq repeat", int'(prev_pulse_mi && match_irq), 0);
            end
            prev_pulse_hd = hblank_dma;
            prev_pulse_mi = match_irq;
        end
    end

    task automatic write_cfg(input logic [RW-1:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        prev_pulse_hd = 1'b0;
        prev_pulse_mi = 1'b0;
        rst       = 1'b1;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 R4 R6 R7: one frame with everything disabled
        repeat (160) @(negedge clk);
        // R8: all enables, target 5, read-only bits driven high
        write_cfg({4'd5, 3'b111, 3'b111});
        repeat (300) @(negedge clk);
        // R5: target 0 matches at the wrap, only match enabled
        write_cfg({4'd0, 3'b100, 3'b000});
        repeat (160) @(negedge clk);
        // R7 R5: target on the last line, all enables
        write_cfg({4'(NL - 1), 3'b111, 3'b000});
        repeat (160) @(negedge clk);
        // R5: out-of-range target never matches
        write_cfg({4'd15, 3'b101, 3'b010});
        repeat (60) @(negedge clk);
        // R1: reset in mid-line
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule